// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block derives a slower clock from the system clock and drives it onto a single output pin. A requester hands over a total division ratio together with three mode bits: the counter width (8 or 16 bits), the output style (50% duty PWM compare or compare-match toggle) and the prescaler ladder to search (standard or fine-grained). The block fits the ratio into the counter by stepping up a power-of-two prescaler ladder, one rung per cycle. It then applies the new counter top, compare threshold and prescale all at once, and restarts the waveform from zero. The ratio it actually achieved is reported on a readback port, so software can see how far integer truncation moved it from the request.

A request is a valid/ready transfer. `req_ready` is high while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and all request fields are sampled in that cycle. `req_ready` then stays low until the result is in force, which means either the new setting is running or the error flag is set. A requester that holds `req_valid` high while `req_ready` is low is stalled without loss. Error flag, readback and clock pin are plain status and data outputs with no handshake.

Top module: `divclk_gen`

## Requirements
- R1: `req_ready` is high when idle. A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after acceptance and stays low until the result (new setting or error) is visible on `eff_div` and `cfg_err`.
- R2: A requested ratio below 2 is rejected. `cfg_err` goes to 1, while `eff_div` and the running output waveform stay as they were.
- R3: In 8-bit mode with toggle style (`req_toggle`=1, `req_wide`=0), the ratio is halved (rounded down) before fitting, and the readback is doubled. In 16-bit mode `req_toggle` is ignored and the output is PWM.
- R4: A request whose value after any halving exceeds 1024 times the counter range (256 in 8-bit mode, 65536 in 16-bit mode) is rejected as in R2.
- R5: With `req_fine`=0, the fitted value is repeatedly divided (rounded down) by 8, 8, 4, 4 in turn while it exceeds the counter range. The possible total prescales are 1, 8, 64, 256 and 1024.
- R6: With `req_fine`=1, the ladder ratios are 8, 4, 2, 2, 2, 4 in turn. The possible total prescales are 1, 8, 32, 64, 128, 256 and 1024.
- R7: The counter top is the fitted value minus one. `eff_div` = fitted value × total prescale (× 2 for a toggle output), and the period of `clk_out` in system clock cycles equals `eff_div`.
- R8: In PWM style, `clk_out` is high for (top/2 + 1) × prescale cycles of each period.
- R9: A successful load restarts both counters from zero. `clk_out` is low in the first cycle in which `req_ready` is high again.
- R10: After reset the divider is stopped: `clk_out` is held low, `cfg_err` is 0, `eff_div` is 0 and `req_ready` is 1.
- R11: `cfg_err` stays set until the next successful load clears it, and only a successful load clears it.
- R12: In toggle style, `clk_out` is high for exactly half of each period, (top+1) × prescale cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_div | input | DIV_W | Requested total division ratio |
| req_wide | input | 1 | 1: 16-bit counter, 0: 8-bit counter |
| req_toggle | input | 1 | 1: toggle-on-match output (8-bit only), 0: PWM |
| req_fine | input | 1 | 1: fine prescaler ladder, 0: standard ladder |
| clk_out | output | 1 | Divided clock output |
| cfg_err | output | 1 | Last request was rejected |
| eff_div | output | DIV_W | Effective division ratio in force |

## Verification
The assertions check, on every cycle, the parts of the contract that are pure sequencing. These are: the handshake drops ready after an accept, the output stays low while stopped, a rejection sets the flag and leaves the readback alone, the readback moves only on a successful load, and the flag clears only on a successful load. The bench scenarios are needed to show the arithmetic: which ladder rung was chosen, the halving and doubling for toggle outputs, the overflow limits, and the measured period and high time of `clk_out`. A model computes the expected values independently and compares them with the readback for each request.

// File: rtl/divclk_pkg.sv
package divclk_pkg;

  // Largest total prescale is 2**PSC_MAX_SH.
  localparam int PSC_MAX_SH = 10;
  localparam int LADDER_IW  = 3;

  typedef enum logic [1:0] {
    F_IDLE,
    F_STEP,
    F_DONE
  } fit_state_t;

  // log2 of the ladder ratio at rung idx; 0 marks the end of the ladder.
  function automatic logic [3:0] ladder_shift(input logic fine, input logic [LADDER_IW-1:0] idx);
    logic [3:0] s;
    s = 4'd0;
    if (fine) begin
      case (idx)
        3'd0: s = 4'd3;
        3'd1: s = 4'd2;
        3'd2: s = 4'd1;
        3'd3: s = 4'd1;
        3'd4: s = 4'd1;
        3'd5: s = 4'd2;
        default: s = 4'd0;
      endcase
    end else begin
      case (idx)
        3'd0: s = 4'd3;
        3'd1: s = 4'd3;
        3'd2: s = 4'd2;
        3'd3: s = 4'd2;
        default: s = 4'd0;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/divclk_fit.sv
module divclk_fit
  import divclk_pkg::*;
#(
  parameter int DIV_W    = 32,
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic             wide,
  input  logic             toggle,
  input  logic             fine,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] res_top,
  output logic [CNT_W-1:0] res_thr,
  output logic [3:0]       res_shamt,
  output logic             res_toggle,
  output logic [DIV_W-1:0] res_eff
);

  localparam int EW = DIV_W + CNT_W + PSC_MAX_SH + 2;

  fit_state_t           state_q;
  logic [DIV_W-1:0]     v_q;
  logic [3:0]           shamt_q;
  logic [LADDER_IW-1:0] idx_q;
  logic                 wide_q, fine_q, tog_q, fail_q;

  logic             tog_in;
  logic [DIV_W-1:0] v_in;
  logic [EW-1:0]    rng_in, lim_in, rng_cur;
  logic [3:0]       step_sh;
  logic [EW-1:0]    eff_wide;
  logic [DIV_W-1:0] top_full;

  always_comb begin
    tog_in  = toggle & ~wide;
    v_in    = tog_in ? (div >> 1) : div;
    rng_in  = wide ? (EW'(1) << CNT_W) : (EW'(1) << NARROW_W);
    lim_in  = rng_in << PSC_MAX_SH;
    rng_cur = wide_q ? (EW'(1) << CNT_W) : (EW'(1) << NARROW_W);
    step_sh = ladder_shift(fine_q, idx_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= F_IDLE;
      v_q     <= '0;
      shamt_q <= '0;
      idx_q   <= '0;
      wide_q  <= 1'b0;
      fine_q  <= 1'b0;
      tog_q   <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      case (state_q)
        F_IDLE: begin
          if (start) begin
            v_q     <= v_in;
            shamt_q <= '0;
            idx_q   <= '0;
            wide_q  <= wide;
            fine_q  <= fine;
            tog_q   <= tog_in;
            if ((div < DIV_W'(2)) || (EW'(v_in) > lim_in)) begin
              fail_q  <= 1'b1;
              state_q <= F_DONE;
            end else begin
              fail_q  <= 1'b0;
              state_q <= F_STEP;
            end
          end
        end
        F_STEP: begin
          if (EW'(v_q) > rng_cur) begin
            if (step_sh == 4'd0) begin
              fail_q  <= 1'b1;
              state_q <= F_DONE;
            end else begin
              v_q     <= v_q >> step_sh;
              shamt_q <= shamt_q + step_sh;
              idx_q   <= idx_q + 1'b1;
            end
          end else begin
            fail_q  <= (v_q == '0);
            state_q <= F_DONE;
          end
        end
        default: state_q <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    top_full   = v_q - DIV_W'(1);
    res_top    = top_full[CNT_W-1:0];
    res_thr    = res_top >> 1;
    res_shamt  = shamt_q;
    res_toggle = tog_q;
    eff_wide   = (EW'(v_q) << shamt_q) << tog_q;
    res_eff    = eff_wide[DIV_W-1:0];
    busy       = (state_q != F_IDLE);
    done       = (state_q == F_DONE);
    fail       = fail_q;
  end

endmodule

// File: rtl/divclk_presc.sv
module divclk_presc
  import divclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [3:0] shamt,
  output logic       tick
);

  logic [PSC_MAX_SH-1:0] pre_q;
  logic [PSC_MAX_SH:0]   mask_w;
  logic [PSC_MAX_SH-1:0] mask;

  always_comb begin
    mask_w = (PSC_MAX_SH+1)'((PSC_MAX_SH+1)'(1) << shamt) - (PSC_MAX_SH+1)'(1);
    mask   = mask_w[PSC_MAX_SH-1:0];
    tick   = run & ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) pre_q <= '0;
    else                           pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/divclk_wave.sv
module divclk_wave #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] top,
  input  logic [CNT_W-1:0] thr,
  input  logic             toggle,
  output logic             pin
);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == top);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
      pin   <= 1'b0;
    end else if (!run) begin
      pin   <= 1'b0;
    end else begin
      if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (toggle) begin
        if (tick && wrap) pin <= ~pin;
      end else begin
        pin <= (cnt_q <= thr);
      end
    end
  end

endmodule

// File: rtl/divclk_gen.sv
module divclk_gen #(
  parameter int DIV_W    = 32,
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [DIV_W-1:0] req_div,
  input  logic             req_wide,
  input  logic             req_toggle,
  input  logic             req_fine,
  output logic             clk_out,
  output logic             cfg_err,
  output logic [DIV_W-1:0] eff_div
);

  logic             fit_busy, fit_done, fit_fail;
  logic [CNT_W-1:0] fit_top, fit_thr;
  logic [3:0]       fit_shamt;
  logic             fit_tog;
  logic [DIV_W-1:0] fit_eff;
  logic             start, load_ok, tick;

  logic             run_q, tog_q, err_q;
  logic [3:0]       shamt_q;
  logic [CNT_W-1:0] top_q, thr_q;
  logic [DIV_W-1:0] eff_q;

  assign req_ready = ~fit_busy;
  assign start     = req_valid & req_ready;
  assign load_ok   = fit_done & ~fit_fail;

  divclk_fit #(.DIV_W(DIV_W), .CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_fit (
    .clk(clk), .rst_n(rst_n), .start(start), .div(req_div), .wide(req_wide),
    .toggle(req_toggle), .fine(req_fine), .busy(fit_busy), .done(fit_done),
    .fail(fit_fail), .res_top(fit_top), .res_thr(fit_thr), .res_shamt(fit_shamt),
    .res_toggle(fit_tog), .res_eff(fit_eff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      tog_q   <= 1'b0;
      err_q   <= 1'b0;
      shamt_q <= '0;
      top_q   <= '0;
      thr_q   <= '0;
      eff_q   <= '0;
    end else if (fit_done) begin
      if (fit_fail) begin
        err_q <= 1'b1;
      end else begin
        err_q   <= 1'b0;
        run_q   <= 1'b1;
        tog_q   <= fit_tog;
        shamt_q <= fit_shamt;
        top_q   <= fit_top;
        thr_q   <= fit_thr;
        eff_q   <= fit_eff;
      end
    end
  end

  divclk_presc u_presc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .restart(load_ok), .shamt(shamt_q), .tick(tick)
  );

  divclk_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .run(run_q), .restart(load_ok), .tick(tick),
    .top(top_q), .thr(thr_q), .toggle(tog_q), .pin(clk_out)
  );

  assign cfg_err = err_q;
  assign eff_div = eff_q;

endmodule

// File: rtl/divclk_chk.sv
module divclk_chk #(
  parameter int DIV_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             clk_out,
  input logic             cfg_err,
  input logic [DIV_W-1:0] eff_div,
  input logic             run,
  input logic             fit_done,
  input logic             fit_fail
);

  assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_reject_keeps_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fit_done && fit_fail) |=> (cfg_err && $stable(eff_div)));

  assert_readback_moves_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fit_done && !fit_fail) |=> $stable(eff_div));

  assert_stopped_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !clk_out);

  assert_err_clear_on_success_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_err) |-> $past(fit_done && !fit_fail));

endmodule

bind divclk_gen divclk_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .clk_out(clk_out), .cfg_err(cfg_err), .eff_div(eff_div), .run(run_q),
  .fit_done(fit_done), .fit_fail(fit_fail)
);

// File: tb/divclk_gen_test.sv
`timescale 1ns/1ps
module divclk_gen_test;
  localparam int DIV_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [DIV_W-1:0] req_div = '0;
  logic             req_wide = 1'b0, req_toggle = 1'b0, req_fine = 1'b0;
  logic             clk_out, cfg_err;
  logic [DIV_W-1:0] eff_div;

  always #2 clk = ~clk;

  divclk_gen #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_div(req_div), .req_wide(req_wide), .req_toggle(req_toggle), .req_fine(req_fine),
    .clk_out(clk_out), .cfg_err(cfg_err), .eff_div(eff_div)
  );

  typedef struct {
    string  tag;
    bit     err;
    longint eff;
    bit     meas;
    longint per;
    longint high;
  } exp_t;

  exp_t   sb[$];
  int     checks = 0, errors = 0;
  int     go_cnt = 0, done_cnt = 0;
  longint cyc = 0;
  bit     finished = 0;
  longint last_eff = 0, last_high = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Spec model of the fitting search.
  task automatic model(input longint d, input bit w, t, f,
                       output bit ok, output longint eff, output longint high);
    int sh_std[4]  = '{3, 3, 2, 2};
    int sh_fine[6] = '{3, 2, 1, 1, 1, 2};
    bit tg;
    longint v, rng, p;
    int sh, idx, step;
    tg  = t && !w;
    v   = tg ? d / 2 : d;
    rng = w ? 65536 : 256;
    ok  = (d >= 2) && (v <= 1024 * rng);
    sh  = 0;
    idx = 0;
    if (ok) begin
      while (v > rng) begin
        if (f) step = (idx < 6) ? sh_fine[idx] : 0;
        else   step = (idx < 4) ? sh_std[idx] : 0;
        if (step == 0) begin ok = 0; break; end
        v = v >> step;
        sh += step;
        idx++;
      end
    end
    if (ok && v == 0) ok = 0;
    p    = longint'(1) << sh;
    eff  = v * p * (tg ? 2 : 1);
    high = tg ? v * p : ((v - 1) / 2 + 1) * p;
  endtask

  task automatic send(input longint d, input bit w, t, f, input bit meas, input string tag);
    exp_t it;
    bit ok;
    longint e, h;
    model(d, w, t, f, ok, e, h);
    if (ok) begin
      last_eff  = e;
      last_high = h;
    end
    it.tag  = tag;
    it.err  = !ok;
    it.eff  = last_eff;
    it.meas = meas;
    it.per  = last_eff;
    it.high = last_high;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid  = 1'b1;
    req_div    = DIV_W'(d);
    req_wide   = w;
    req_toggle = t;
    req_fine   = f;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1 ready low after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
    if (ok) check(clk_out == 1'b0, "R9 output restarts low", clk_out, 0);
    sb.push_back(it);
    go_cnt++;
    wait (done_cnt == go_cnt);
  endtask

  task automatic wait_level(input bit lvl);
    do @(negedge clk); while (clk_out != lvl);
  endtask

  // Scoreboard monitor: pops each expected item once its result is in force.
  initial begin
    forever begin
      exp_t it;
      longint t0, t1, t2;
      wait (go_cnt > done_cnt);
      it = sb.pop_front();
      check(cfg_err == it.err, {it.tag, " error flag"}, cfg_err, it.err);
      check(longint'(eff_div) == it.eff, {it.tag, " readback"}, eff_div, it.eff);
      if (it.meas) begin
        wait_level(0); wait_level(1); t0 = cyc;
        wait_level(0); t1 = cyc;
        wait_level(1); t2 = cyc;
        check((t2 - t0) == it.per, {it.tag, " R7 period"}, t2 - t0, it.per);
        check((t1 - t0) == it.high, {it.tag, " high time"}, t1 - t0, it.high);
      end
      done_cnt++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: stopped state after reset
    check(clk_out == 0 && cfg_err == 0, "R10 idle outputs", {clk_out, cfg_err}, 0);
    check(eff_div == 0, "R10 readback zero", eff_div, 0);
    check(req_ready == 1, "R1 ready when idle", req_ready, 1);
    begin
      bit seen = 0;
      repeat (50) begin @(negedge clk); if (clk_out) seen = 1; end
      check(!seen, "R10 held low while stopped", seen, 0);
    end

    send(10, 0, 0, 0, 1, "R8 pwm div10");
    send(1, 0, 0, 0, 1, "R2 reject div1");
    send(0, 0, 0, 0, 0, "R2 reject div0");
    send(1000, 0, 0, 0, 1, "R11 R5 pwm div1000 clears err");
    send(7, 0, 1, 0, 1, "R3 R12 toggle div7");
    send(3000, 0, 1, 0, 1, "R3 R12 toggle div3000");
    send(2100, 0, 0, 1, 1, "R6 fine ladder div2100");
    send(2100, 0, 0, 0, 1, "R5 std ladder div2100");
    send(300, 1, 1, 0, 1, "R3 wide ignores toggle div300");
    send(262145, 0, 0, 0, 0, "R4 narrow overflow");
    send(262144, 0, 0, 0, 0, "R4 R5 narrow limit");
    send(524290, 0, 1, 0, 0, "R4 toggle overflow");
    send(524289, 0, 1, 0, 0, "R4 R3 toggle limit");
    send(67108865, 1, 0, 0, 0, "R4 wide overflow");
    send(2, 0, 0, 0, 1, "R8 pwm div2");
    send(3, 0, 1, 0, 1, "R3 R12 toggle div3");
    send(1, 0, 1, 0, 1, "R2 reject keeps toggle");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule